// File: doc/BRIEF.md
# Processor Watchdog Supervisor

This block watches a processor's heartbeat line and pulls an active-low supervisor output low when the heartbeat stops. The time base is a slow watchdog tick. The block makes that tick from the system clock, through a programmable divider. The heartbeat line is asynchronous to the clock. It is synchronised first, and then each high pulse is judged on tick samples. A pulse counts as a kick only if it is wide enough and follows a low sample. A valid kick restarts a fixed-length tick count. If the count runs out, the output drops for a set number of ticks and then comes back high with a fresh count.

Power-good arrives as a digital input and has priority. While it is low, the output is low and the counter is cleared. A bypass strap takes the watchdog out of service. The output then mirrors power-good exactly, and the counter stays idle. The divider setting lets an integrator stretch or shrink the full timeout without changing the fixed tick count.

Top module: `wdt_supervisor`

## Requirements
- R1: With no valid kick, the output goes low at the TIMEOUT_TICKS-th tick (default 57,344) after the last restart, and not one tick earlier.
- R2: A kick is valid when the synchronised heartbeat is sampled high on two consecutive ticks after having been sampled low on an earlier tick. The count restarts on the tick where the second high sample is taken. If that tick is also the expiry tick, the restart wins and the output stays high.
- R3: A heartbeat high pulse seen on fewer than two consecutive ticks is ignored and does not move the expiry.
- R4: After an expiry, the output stays low for HOLD_TICKS ticks (default 64). It then returns high, and a new timeout period starts from zero.
- R5: A valid kick that arrives while the output is held low after an expiry neither releases the output early nor lengthens the hold.
- R6: While the bypass strap is high, the output equals power-good in the same cycle, and the timeout counter stays idle at zero.
- R7: While power-good is low, the output is low and the timeout counter is cleared. When power-good returns, the output goes high in the same cycle and a full period starts.
- R8: A tick occurs once every tick_div_i+1 clock cycles. After leaving reset, or after an idle condition (power-good low or bypass) ends, the k-th tick falls on the k*(tick_div_i+1)-th clock edge counted from zero at the first edge. The heartbeat passes a two-flop synchroniser, so a level present at edge n is seen by tick logic at edge n+2.
- R9: In reset (synchronous, active low), the output follows power-good and the timeout counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kick_i | input | 1 | Asynchronous heartbeat from the monitored processor |
| pwr_ok_i | input | 1 | Power-good, already digital |
| bypass_i | input | 1 | Strap that takes the watchdog out of service |
| tick_div_i | input | DIV_W | Tick period minus one, in clock cycles |
| wdo_n_o | output | 1 | Active-low supervisor output to the processor reset |

## Verification
Two events can land on the same tick: a kick whose second high sample qualifies it, and the expiry of the timeout count. The bench sets the divider to two clocks per tick and starts a full period from power-good. It then times a heartbeat pulse so that it qualifies exactly on the final tick of the period. The restart must win. So the output is required to stay high across that edge and for several cycles after it. An output that drops shows that expiry was given priority.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic [1:0] {
      WDT_IDLE = 2'd0,
      WDT_RUN  = 2'd1,
      WDT_HOLD = 2'd2
   } wdt_state_e;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt_q;

   // compare with >= so that a divider lowered mid-count cannot overrun
   assign tick_o = !hold_i && (cnt_q >= div_i);

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt_q <= '0;
      else if (hold_i || tick_o) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/wdt_kick_qual.sv
module wdt_kick_qual #(
   parameter int SYNC_STAGES    = 2,
   parameter int KICK_MIN_TICKS = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick_i,
   input  logic tick_i,
   output logic kick_ok_o
);
   localparam int RUN_W = (KICK_MIN_TICKS > 1) ? $clog2(KICK_MIN_TICKS) : 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   lvl;
   logic                   armed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], kick_i};
   end
   assign lvl = sync_q[SYNC_STAGES-1];

   // a kick needs a low sample first, so one long high level is one kick
   always_ff @(posedge clk) begin
      if (!rst_n)                armed_q <= 1'b0;
      else if (tick_i && !lvl)   armed_q <= 1'b1;
      else if (kick_ok_o)        armed_q <= 1'b0;
   end

   generate
      if (KICK_MIN_TICKS == 1) begin : g_single
         assign kick_ok_o = tick_i && lvl && armed_q;
      end else begin : g_width
         logic [RUN_W-1:0] run_q;
         assign kick_ok_o = tick_i && lvl && armed_q &&
                            (run_q == RUN_W'(KICK_MIN_TICKS-1));
         always_ff @(posedge clk) begin
            if (!rst_n)
               run_q <= '0;
            else if (tick_i) begin
               if (!lvl)
                  run_q <= '0;
               else if (run_q != RUN_W'(KICK_MIN_TICKS-1))
                  run_q <= run_q + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/wdt_core.sv
module wdt_core
   import wdt_pkg::*;
#(
   parameter int TIMEOUT_TICKS = 57344,
   parameter int HOLD_TICKS    = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_ok_i,
   input  logic       bypass_i,
   input  logic       tick_i,
   input  logic       kick_ok_i,
   output wdt_state_e st_o,
   output logic       idle_o
);
   localparam int TCW = $clog2(TIMEOUT_TICKS);
   localparam int HCW = $clog2(HOLD_TICKS + 1);

   wdt_state_e st_q, st_d;
   logic [TCW-1:0] tcnt_q, tcnt_d;
   logic [HCW-1:0] hcnt_q, hcnt_d;

   always_comb begin
      st_d   = st_q;
      tcnt_d = tcnt_q;
      hcnt_d = hcnt_q;
      if (!pwr_ok_i || bypass_i) begin
         st_d   = WDT_IDLE;
         tcnt_d = '0;
         hcnt_d = '0;
      end else begin
         case (st_q)
            WDT_IDLE: begin
               st_d   = WDT_RUN;
               tcnt_d = '0;
               hcnt_d = '0;
            end
            WDT_RUN: begin
               if (kick_ok_i)
                  tcnt_d = '0;
               else if (tick_i) begin
                  if (tcnt_q == TCW'(TIMEOUT_TICKS-1)) begin
                     st_d   = WDT_HOLD;
                     tcnt_d = '0;
                     hcnt_d = '0;
                  end else begin
                     tcnt_d = tcnt_q + 1'b1;
                  end
               end
            end
            WDT_HOLD: begin
               if (tick_i) begin
                  if (hcnt_q == HCW'(HOLD_TICKS-1)) begin
                     st_d   = WDT_RUN;
                     hcnt_d = '0;
                     tcnt_d = '0;
                  end else begin
                     hcnt_d = hcnt_q + 1'b1;
                  end
               end
            end
            default: st_d = WDT_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= WDT_IDLE;
         tcnt_q <= '0;
         hcnt_q <= '0;
      end else begin
         st_q   <= st_d;
         tcnt_q <= tcnt_d;
         hcnt_q <= hcnt_d;
      end
   end

   assign st_o   = st_q;
   assign idle_o = !pwr_ok_i || bypass_i || (st_q == WDT_IDLE);
endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
   import wdt_pkg::*;
#(
   parameter int DIV_W          = 16,
   parameter int TIMEOUT_TICKS  = 57344,
   parameter int HOLD_TICKS     = 64,
   parameter int SYNC_STAGES    = 2,
   parameter int KICK_MIN_TICKS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kick_i,
   input  logic             pwr_ok_i,
   input  logic             bypass_i,
   input  logic [DIV_W-1:0] tick_div_i,
   output logic             wdo_n_o
);
   generate
      if (TIMEOUT_TICKS < 2) begin : g_bad_timeout
         $error("wdt_supervisor: TIMEOUT_TICKS must be at least 2");
      end
      if (HOLD_TICKS < 1) begin : g_bad_hold
         $error("wdt_supervisor: HOLD_TICKS must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("wdt_supervisor: SYNC_STAGES must be at least 2");
      end
      if (KICK_MIN_TICKS < 1) begin : g_bad_kick
         $error("wdt_supervisor: KICK_MIN_TICKS must be at least 1");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("wdt_supervisor: DIV_W must be at least 1");
      end
   endgenerate

   logic       tick_w;
   logic       kick_ok_w;
   logic       idle_w;
   wdt_state_e st_w;

   wdt_tick_gen #(.DIV_W(DIV_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold_i (idle_w),
      .div_i  (tick_div_i),
      .tick_o (tick_w)
   );

   wdt_kick_qual #(
      .SYNC_STAGES   (SYNC_STAGES),
      .KICK_MIN_TICKS(KICK_MIN_TICKS)
   ) u_kick (
      .clk       (clk),
      .rst_n     (rst_n),
      .kick_i    (kick_i),
      .tick_i    (tick_w),
      .kick_ok_o (kick_ok_w)
   );

   wdt_core #(
      .TIMEOUT_TICKS(TIMEOUT_TICKS),
      .HOLD_TICKS   (HOLD_TICKS)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_ok_i  (pwr_ok_i),
      .bypass_i  (bypass_i),
      .tick_i    (tick_w),
      .kick_ok_i (kick_ok_w),
      .st_o      (st_w),
      .idle_o    (idle_w)
   );

   assign wdo_n_o = pwr_ok_i && (bypass_i || (st_w != WDT_HOLD));
endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk
   import wdt_pkg::*;
#(
   parameter int TIMEOUT_TICKS = 57344,
   parameter int HOLD_TICKS    = 64
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             pwr_ok_i,
   input logic                             bypass_i,
   input logic                             wdo_n_o,
   input logic                             tick,
   input logic                             kick_ok,
   input wdt_state_e                       st,
   input logic [$clog2(TIMEOUT_TICKS)-1:0] tcnt,
   input logic [$clog2(HOLD_TICKS+1)-1:0]  hcnt
);
   localparam int TCW = $clog2(TIMEOUT_TICKS);
   localparam int HCW = $clog2(HOLD_TICKS + 1);

   logic live;
   assign live = pwr_ok_i && !bypass_i;

   assert_expiry_enters_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (live && st == WDT_RUN && tick && !kick_ok && tcnt == TCW'(TIMEOUT_TICKS-1))
      |=> (st == WDT_HOLD));

   assert_count_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tcnt <= TCW'(TIMEOUT_TICKS-1)));

   assert_kick_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (live && st == WDT_RUN && kick_ok) |=> (st == WDT_RUN && tcnt == '0));

   assert_hold_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (live && st == WDT_HOLD && tick && hcnt == HCW'(HOLD_TICKS-1))
      |=> (st == WDT_RUN && tcnt == '0));

   assert_late_kick_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (live && st == WDT_HOLD && kick_ok && hcnt != HCW'(HOLD_TICKS-1))
      |=> (st == WDT_HOLD));

   assert_bypass_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      bypass_i |=> (st == WDT_IDLE && tcnt == '0));

   assert_pwr_low_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_ok_i |=> (tcnt == '0 && st == WDT_IDLE));

   assert_high_needs_power_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wdo_n_o |-> pwr_ok_i);
endmodule

bind wdt_supervisor wdt_supervisor_chk #(
   .TIMEOUT_TICKS(TIMEOUT_TICKS),
   .HOLD_TICKS   (HOLD_TICKS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pwr_ok_i (pwr_ok_i),
   .bypass_i (bypass_i),
   .wdo_n_o  (wdo_n_o),
   .tick     (tick_w),
   .kick_ok  (kick_ok_w),
   .st       (st_w),
   .tcnt     (u_core.tcnt_q),
   .hcnt     (u_core.hcnt_q)
);

// File: tb/wdt_supervisor_test.sv
module wdt_supervisor_test;
   localparam int DIV_W = 16;
   localparam int TO    = 57344;
   localparam int HOLD  = 64;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             kick;
   logic             pwr;
   logic             byp;
   logic [DIV_W-1:0] div;
   logic             wdo_n;

   int total_edges = 0;
   int base = 0;
   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) total_edges <= total_edges + 1;

   wdt_supervisor #(.DIV_W(DIV_W)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .kick_i     (kick),
      .pwr_ok_i   (pwr),
      .bypass_i   (byp),
      .tick_div_i (div),
      .wdo_n_o    (wdo_n)
   );

   // Edge E0 is the first posedge after a mark; the negedge with rel==n precedes E_n.
   task automatic go_to(input int n);
      while ((total_edges - base) != n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: wdo_n actual=%0b expected=%0b at edge %0d",
                  req, act, exp, total_edges - base);
      end
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         report();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; kick = 1'b0; pwr = 1'b1; byp = 1'b0; div = '0;
      repeat (3) @(negedge clk);
      #1 check("R9 reset follows power-good high", wdo_n, 1'b1);
      pwr = 1'b0;
      #1 check("R9 reset follows power-good low", wdo_n, 1'b0);
      pwr = 1'b1;

      // Run 1: one tick per clock, tick k on edge E_k
      @(negedge clk);
      rst_n = 1'b1;
      base = total_edges;

      // wide kick at E500..E501, qualifies at E503
      go_to(500); kick = 1'b1;
      go_to(502); kick = 1'b0;
      // narrow kick, one sample high: must be ignored (R3)
      go_to(2000); kick = 1'b1;
      go_to(2001); kick = 1'b0;

      go_to(TO + 1);
      #1 check("R2 restart moved expiry past first period", wdo_n, 1'b1);
      go_to(503 + TO);
      #1 check("R1 still high one tick before expiry", wdo_n, 1'b1);
      go_to(503 + TO + 1);
      #1 check("R1 R3 low exactly at expiry after valid kick", wdo_n, 1'b0);

      // late kick during hold
      go_to(503 + TO + 13); kick = 1'b1;
      go_to(503 + TO + 17); kick = 1'b0;
      go_to(503 + TO + 23);
      #1 check("R5 late kick does not release output", wdo_n, 1'b0);
      go_to(503 + TO + HOLD);
      #1 check("R4 R5 still low on last hold tick", wdo_n, 1'b0);
      go_to(503 + TO + HOLD + 1);
      #1 check("R4 released after hold ticks", wdo_n, 1'b1);
      go_to(503 + TO + HOLD + 20);
      #1 check("R4 new period running, output high", wdo_n, 1'b1);

      // bypass mirrors power-good
      byp = 1'b1;
      #1 check("R6 bypass with power-good high", wdo_n, 1'b1);
      pwr = 1'b0;
      #1 check("R6 bypass with power-good low", wdo_n, 1'b0);
      @(negedge clk);
      pwr = 1'b1;
      #1 check("R6 bypass follows power-good rise", wdo_n, 1'b1);
      repeat (50) @(negedge clk);
      #1 check("R6 bypass stays mirrored", wdo_n, 1'b1);

      // power-good low with watchdog in service
      @(negedge clk);
      pwr = 1'b0; byp = 1'b0;
      #1 check("R7 power-good low forces output low", wdo_n, 1'b0);
      repeat (20) @(negedge clk);
      #1 check("R7 output held low while power-good low", wdo_n, 1'b0);

      // Run 2: two clocks per tick, tick k on edge E_2k
      @(negedge clk);
      div = DIV_W'(1);
      pwr = 1'b1;
      base = total_edges;
      #1 check("R7 output high as power-good returns", wdo_n, 1'b1);

      // qualify exactly on tick TO (edge E_2TO): collision with expiry
      go_to(2*TO - 4); kick = 1'b1;
      go_to(2*TO - 1); kick = 1'b0;
      go_to(2*TO);
      #1 check("R8 high before final tick of divided period", wdo_n, 1'b1);
      go_to(2*TO + 1);
      #1 check("R2 kick on expiry tick wins", wdo_n, 1'b1);
      go_to(2*TO + 12);
      #1 check("R2 R8 restarted period stays high", wdo_n, 1'b1);

      done = 1'b1;
      report();
      $finish;
   end
endmodule